// File: doc/BRIEF.md
# Interrupt Source Coalescing State Controller

This block keeps a two-bit coalescing state for each of a set of interrupt sources, so that a source is handed to the downstream routing logic at most once until software acknowledges it. The upper bit (P, bit 1) means an event has been forwarded and is waiting for an end-of-interrupt. The lower bit (Q, bit 0) means a further event arrived while P was set. The encoding 01 is an "off" state that absorbs every event. Events enter the block on dedicated per-source trigger lines and on a 64-bit load/store port. Each source owns one 64 KiB address page on that port. An operation code inside the page selects one of these actions: trigger, end-of-interrupt, read of the state, or a forced write of the state.

Every load is an atomic read-modify-write of one source and returns that source's state from before the operation. When a transition needs the event routed onward, the block records a notification for the source. Notifications drain one at a time, through a small queue, to a valid/ready output that carries the source number. Any access the block does not accept raises a one-cycle invalid-access pulse and leaves all state untouched.

Top module: `pq_src_ctrl`

## Requirements
- R1: After reset every source reads 01 (off), and no notification, read response or invalid-access pulse is present.
- R2: A trigger moves 00 to 10 and raises a notification. It moves 10 to 11 and leaves 11 and 01 unchanged, with no notification in those three cases.
- R3: A store at page offset 0x400 is an end-of-interrupt. It moves 10 to 00 and 11 to 10, and leaves 00 and 01 unchanged. Only the move from 11 raises a notification. A store at offset 0x000 is a trigger. Store data has no effect.
- R4: A load at offset 0x000 applies the end-of-interrupt transition and returns the old state. It never raises a notification.
- R5: A load at offset 0x800 returns the current state in data bits 1:0, with the upper bits zero, and changes nothing.
- R6: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11 respectively, and return the old state.
- R7: The source index is taken from address bits ADDR_W-1:16 and the operation from address bits 11:8. Address bits 15:12 and 7:0 are ignored.
- R8: An access is invalid when its size code is not 3 (8 bytes), its offset is not listed for its direction, or its index is not below N_SRC. An invalid access pulses bad_access_o one cycle later and changes no state. An invalid load returns all ones.
- R9: A rising edge on a trigger line applies one trigger to its source. Holding the line high or lowering it has no further effect.
- R10: A port operation and a line trigger on the same source in one cycle apply the port operation first and then the trigger to its result. At most one notification results.
- R11: Notifications leave in the order they are queued (lowest source first within one cycle). ntf_valid_o and ntf_idx_o hold steady while ntf_ready_i is low.
- R12: A load response appears with bus_rvalid_o in the cycle after the request. A store produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | N_SRC | Per-source trigger lines, rising-edge sensitive |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 for store, 0 for load |
| bus_size_i | input | 2 | log2 of access bytes; only 3 is accepted |
| bus_addr_i | input | ADDR_W | Access address: source page and operation offset |
| bus_wdata_i | input | 64 | Store data, ignored |
| bus_rvalid_o | output | 1 | Load response valid |
| bus_rdata_o | output | 64 | Old state zero-extended, or all ones on an invalid load |
| bad_access_o | output | 1 | One-cycle pulse for an invalid access |
| ntf_valid_o | output | 1 | Notification available |
| ntf_ready_i | input | 1 | Notification accepted |
| ntf_idx_o | output | IDX_W | Source number of the notification |

## Verification
A corrupted state bit in one source stays hidden until that source is touched. It shows either in the old-state value of the next load to the source, one cycle after the request, or as a missing or extra notification two cycles after a trigger or end-of-interrupt. The bench therefore walks each source through every transition and reads it back right after each step. This bounds the time between a wrong state and its detection to a single operation. Queue faults show as a wrong order or a changing index under backpressure. Decode faults show as a response from the wrong source or a missing invalid-access pulse.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;
  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI_ST,
    OP_EOI_LD,
    OP_GET,
    OP_SET
  } op_t;

  localparam int unsigned PAGE_SHIFT = 16;
  localparam logic [1:0]  SIZE_8B    = 2'd3;

  function automatic pq_t pq_on_trig(pq_t s);
    case (s)
      PQ_RESET: return PQ_PEND;
      PQ_PEND:  return PQ_QUEUED;
      default:  return s;
    endcase
  endfunction

  function automatic pq_t pq_on_eoi(pq_t s);
    case (s)
      PQ_PEND:   return PQ_RESET;
      PQ_QUEUED: return PQ_PEND;
      default:   return s;
    endcase
  endfunction
endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_src_pkg::*;
#(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned ADDR_W = 19,
  localparam int unsigned IDX_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_t               op_o,
  output logic [IDX_W-1:0]  idx_o,
  output pq_t               set_val_o,
  output logic              bad_o
);
  localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(N_SRC);

  logic [3:0] off;
  logic       in_range;
  logic       unused_addr_bits;

  assign off              = addr_i[11:8];
  assign idx_o            = addr_i[ADDR_W-1:PAGE_SHIFT];
  assign in_range         = {1'b0, idx_o} < IDX_LIM;
  assign set_val_o        = pq_t'(off[1:0]);
  assign unused_addr_bits = ^{addr_i[15:12], addr_i[7:0]};

  always_comb begin
    op_o  = OP_NONE;
    bad_o = 1'b0;
    if (req_i) begin
      if (size_i != SIZE_8B || !in_range) begin
        bad_o = 1'b1;
      end else if (we_i) begin
        case (off)
          4'h0:    op_o = OP_TRIG;
          4'h4:    op_o = OP_EOI_ST;
          default: bad_o = 1'b1;
        endcase
      end else begin
        case (off)
          4'h0:                      op_o = OP_EOI_LD;
          4'h8:                      op_o = OP_GET;
          4'hC, 4'hD, 4'hE, 4'hF:    op_o = OP_SET;
          default:                   bad_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
  import pq_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  op_t  op_i,
  input  pq_t  set_val_i,
  input  logic trig_i,
  output pq_t  state_o,
  output logic notify_o
);
  pq_t  state_q, mid, nxt;
  logic port_ntf, line_ntf;

  always_comb begin
    mid      = state_q;
    port_ntf = 1'b0;
    case (op_i)
      OP_TRIG: begin
        mid      = pq_on_trig(state_q);
        port_ntf = (state_q == PQ_RESET);
      end
      OP_EOI_ST: begin
        mid      = pq_on_eoi(state_q);
        port_ntf = (state_q == PQ_QUEUED);
      end
      OP_EOI_LD: mid = pq_on_eoi(state_q);
      OP_SET:    mid = set_val_i;
      default:   mid = state_q;
    endcase
    // line trigger applies to the port result
    nxt      = trig_i ? pq_on_trig(mid) : mid;
    line_ntf = trig_i && (mid == PQ_RESET);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PQ_OFF;
    else         state_q <= nxt;
  end

  assign state_o  = state_q;
  assign notify_o = port_ntf | line_ntf;
endmodule

// File: rtl/pq_notify_q.sv
module pq_notify_q #(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned PTR_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned CNT_W = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_SRC - 1);
  localparam logic [CNT_W-1:0] DEPTH    = CNT_W'(N_SRC);

  logic [N_SRC-1:0] flags_q, pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_vld, push, pop;
  logic [IDX_W-1:0] mem_q [N_SRC];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    pick_oh  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (flags_q[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
        pick_oh  = N_SRC'(1) << i;
      end
    end
  end

  assign push    = pick_vld && (cnt_q < DEPTH);
  assign valid_o = (cnt_q != '0);
  assign pop     = valid_o && ready_i;
  assign idx_o   = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < N_SRC; i++) mem_q[i] <= '0;
    end else begin
      // a new request wins over the clear of a flag just moved
      flags_q <= (flags_q & ~(push ? pick_oh : '0)) | req_i;
      if (push) begin
        mem_q[wr_q] <= pick_idx;
        wr_q        <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      end
      if (pop) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/pq_src_ctrl.sv
module pq_src_ctrl
  import pq_src_pkg::*;
#(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned ADDR_W = 19,
  localparam int unsigned IDX_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  trig_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [63:0]       bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [63:0]       bus_rdata_o,
  output logic              bad_access_o,
  output logic              ntf_valid_o,
  input  logic              ntf_ready_i,
  output logic [IDX_W-1:0]  ntf_idx_o
);
  op_t              dec_op;
  logic [IDX_W-1:0] dec_idx;
  pq_t              dec_set;
  logic             dec_bad;
  logic [N_SRC-1:0] trig_q, trig_evt, cell_ntf;
  pq_t              cell_st [N_SRC];
  pq_t              sel_st;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  pq_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_dec (
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .size_i   (bus_size_i),
    .addr_i   (bus_addr_i),
    .op_o     (dec_op),
    .idx_o    (dec_idx),
    .set_val_o(dec_set),
    .bad_o    (dec_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_i;
  end
  assign trig_evt = trig_i & ~trig_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    op_t cell_op;
    assign cell_op = (dec_idx == IDX_W'(g)) ? dec_op : OP_NONE;
    pq_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .op_i     (cell_op),
      .set_val_i(dec_set),
      .trig_i   (trig_evt[g]),
      .state_o  (cell_st[g]),
      .notify_o (cell_ntf[g])
    );
  end

  always_comb begin
    sel_st = PQ_OFF;
    for (int i = 0; i < N_SRC; i++) begin
      if (dec_idx == IDX_W'(i)) sel_st = cell_st[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rvalid_o <= 1'b0;
      bus_rdata_o  <= '0;
      bad_access_o <= 1'b0;
    end else begin
      bus_rvalid_o <= bus_req_i && !bus_we_i;
      bad_access_o <= dec_bad;
      if (bus_req_i && !bus_we_i)
        bus_rdata_o <= dec_bad ? '1 : {62'd0, sel_st};
    end
  end

  pq_notify_q #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_ntf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (cell_ntf),
    .valid_o(ntf_valid_o),
    .ready_i(ntf_ready_i),
    .idx_o  (ntf_idx_o)
  );
endmodule

// File: rtl/pq_src_chk.sv
module pq_src_chk #(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_req_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_size_i,
  input logic             bus_rvalid_o,
  input logic [63:0]      bus_rdata_o,
  input logic             bad_access_o,
  input logic             ntf_valid_o,
  input logic             ntf_ready_i,
  input logic [IDX_W-1:0] ntf_idx_o
);
  // R8
  bad_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_size_i != 2'd3) |=> bad_access_o);

  // R8
  bad_load_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rvalid_o && bad_access_o) |-> (bus_rdata_o == '1));

  // R5
  good_load_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rvalid_o && !bad_access_o) |-> (bus_rdata_o[63:2] == '0));

  // R12
  rvalid_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(bus_req_i && !bus_we_i));

  // R12
  store_no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i) |=> !bus_rvalid_o);

  // R11
  ntf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ntf_valid_o && !ntf_ready_i) |=> (ntf_valid_o && $stable(ntf_idx_o)));

  // R11
  ntf_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ntf_valid_o |-> ({1'b0, ntf_idx_o} < (IDX_W+1)'(N_SRC)));
endmodule

bind pq_src_ctrl pq_src_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_size_i  (bus_size_i),
  .bus_rvalid_o(bus_rvalid_o),
  .bus_rdata_o (bus_rdata_o),
  .bad_access_o(bad_access_o),
  .ntf_valid_o (ntf_valid_o),
  .ntf_ready_i (ntf_ready_i),
  .ntf_idx_o   (ntf_idx_o)
);

// File: tb/sim_pq_src_ctrl.sv
module sim_pq_src_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC  = 6;
  localparam int ADDR_W = 19;
  localparam int IDX_W  = 3;
  localparam int NV     = 29;

  // entry: [16] we, [15:12] op nibble, [11:4] index, [3] bad, [2:1] old state, [0] notification
  localparam logic [16:0] TBL [NV] = '{
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b01, 1'b0},  // R1 R5 off after reset
    {1'b1, 4'h0, 8'd2, 1'b0, 2'b00, 1'b0},  // R2 off absorbs
    {1'b0, 4'hC, 8'd2, 1'b0, 2'b01, 1'b0},  // R6 force 00
    {1'b1, 4'h0, 8'd2, 1'b0, 2'b00, 1'b1},  // R2 00->10 notify
    {1'b1, 4'h0, 8'd2, 1'b0, 2'b00, 1'b0},  // R2 10->11
    {1'b1, 4'h0, 8'd2, 1'b0, 2'b00, 1'b0},  // R2 11 stays
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b11, 1'b0},
    {1'b1, 4'h4, 8'd2, 1'b0, 2'b00, 1'b1},  // R3 11->10 notify
    {1'b1, 4'h4, 8'd2, 1'b0, 2'b00, 1'b0},  // R3 10->00
    {1'b1, 4'h4, 8'd2, 1'b0, 2'b00, 1'b0},  // R3 00 stays
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b00, 1'b0},
    {1'b0, 4'hD, 8'd2, 1'b0, 2'b00, 1'b0},  // R6 force 01
    {1'b1, 4'h4, 8'd2, 1'b0, 2'b00, 1'b0},  // R3 01 stays
    {1'b0, 4'h0, 8'd2, 1'b0, 2'b01, 1'b0},  // R4 eoi on off
    {1'b0, 4'hE, 8'd2, 1'b0, 2'b01, 1'b0},  // R6 force 10
    {1'b0, 4'h0, 8'd2, 1'b0, 2'b10, 1'b0},  // R4 10->00
    {1'b0, 4'hF, 8'd2, 1'b0, 2'b00, 1'b0},  // R6 force 11
    {1'b0, 4'h0, 8'd2, 1'b0, 2'b11, 1'b0},  // R4 11->10, no notify
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b10, 1'b0},
    {1'b0, 4'h9, 8'd2, 1'b1, 2'b00, 1'b0},  // R8 bad load offset
    {1'b1, 4'h8, 8'd2, 1'b1, 2'b00, 1'b0},  // R8 bad store offset
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b10, 1'b0},
    {1'b0, 4'h8, 8'd5, 1'b0, 2'b01, 1'b0},  // R7 other page
    {1'b0, 4'hE, 8'd5, 1'b0, 2'b01, 1'b0},
    {1'b0, 4'h8, 8'd5, 1'b0, 2'b10, 1'b0},
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b10, 1'b0},
    {1'b0, 4'h8, 8'd7, 1'b1, 2'b00, 1'b0},  // R8 index out of range
    {1'b1, 4'h0, 8'd7, 1'b1, 2'b00, 1'b0},
    {1'b0, 4'h8, 8'd2, 1'b0, 2'b10, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_SRC-1:0]  trig = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [1:0]        size = 2'd3;
  logic [ADDR_W-1:0] addr = '0;
  logic [63:0]       wdata = '0;
  logic              rvalid, bad, nvalid;
  logic              nready = 1'b1;
  logic [63:0]       rdata;
  logic [IDX_W-1:0]  nidx;
  int                n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pq_src_ctrl #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .bus_req_i(req), .bus_we_i(we), .bus_size_i(size), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
    .bad_access_o(bad), .ntf_valid_o(nvalid), .ntf_ready_i(nready),
    .ntf_idx_o(nidx)
  );

  function automatic logic [ADDR_W-1:0] mk(int idx, logic [3:0] op);
    return ADDR_W'((idx << 16) | (int'(op) << 8));
  endfunction

  task automatic chk(bit ok, string req_s, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req_s, act, exp);
    end
  endtask

  // drives one access; returns at a falling edge after notification sampling
  task automatic access(input logic w, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                        output logic rv, output logic [63:0] rd, output logic bd,
                        output logic nv, output logic [IDX_W-1:0] ni);
    req = 1'b1; we = w; size = sz; addr = a; wdata = 64'hDEAD_BEEF_0123_4567;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    rv = rvalid; rd = rdata; bd = bad;
    @(posedge clk); @(negedge clk);
    nv = nvalid; ni = nidx;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic get_state(int idx, output logic [1:0] st);
    logic rv, bd, nv;
    logic [63:0] rd;
    logic [IDX_W-1:0] ni;
    access(1'b0, 2'd3, mk(idx, 4'h8), rv, rd, bd, nv, ni);
    st = rd[1:0];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic rv, bd, nv;
    logic [63:0] rd, exp;
    logic [IDX_W-1:0] ni;
    logic [1:0] st;

    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk(!nvalid && !rvalid && !bad, "R1 idle outputs", {nvalid, rvalid, bad}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N_SRC; i++) begin
      get_state(i, st);
      chk(st == 2'b01, "R1 off after reset", st, 2'b01);
    end

    // R2 R3 R4 R5 R6 R8 table walk
    for (int k = 0; k < NV; k++) begin
      logic [16:0] e;
      e = TBL[k];
      access(e[16], 2'd3, mk(int'(e[11:4]), e[15:12]), rv, rd, bd, nv, ni);
      chk(rv == !e[16], $sformatf("R12 step %0d rvalid", k), rv, !e[16]);
      chk(bd == e[3], $sformatf("R8 step %0d bad", k), bd, e[3]);
      if (!e[16]) begin
        exp = e[3] ? '1 : {62'd0, e[2:1]};
        chk(rd == exp, $sformatf("R5 R6 R4 step %0d old state", k), rd, exp);
      end
      chk(nv == e[0], $sformatf("R2 R3 step %0d notify", k), nv, e[0]);
      if (e[0]) chk(ni == e[10:4], $sformatf("R11 step %0d index", k), ni, e[10:4]);
    end

    // R7 ignored address bits
    access(1'b0, 2'd3, mk(2, 4'h8) | 19'h0_F0AB, rv, rd, bd, nv, ni);
    chk(!bd && rd == 64'd2, "R7 ignored bits", rd, 2);

    // R8 bad size: load returns ones, store changes nothing
    access(1'b0, 2'd2, mk(2, 4'hC), rv, rd, bd, nv, ni);
    chk(bd && rd == '1, "R8 bad size load", rd, '1);
    access(1'b1, 2'd1, mk(5, 4'h0), rv, rd, bd, nv, ni);
    chk(bd && !nv, "R8 bad size store", {bd, nv}, 2'b10);
    get_state(5, st);
    chk(st == 2'b10, "R8 state kept", st, 2'b10);
    get_state(2, st);
    chk(st == 2'b10, "R8 state kept src2", st, 2'b10);

    // R9 line trigger: edge only
    access(1'b0, 2'd3, mk(3, 4'hC), rv, rd, bd, nv, ni);
    trig[3] = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    chk(nvalid && nidx == 3'd3, "R9 line notify", {nvalid, nidx}, {1'b1, 3'd3});
    repeat (4) @(negedge clk);
    chk(!nvalid, "R9 held high once", nvalid, 0);
    get_state(3, st);
    chk(st == 2'b10, "R9 one trigger", st, 2'b10);
    trig[3] = 1'b0;
    repeat (2) @(negedge clk);
    get_state(3, st);
    chk(st == 2'b10, "R9 fall no effect", st, 2'b10);
    trig[3] = 1'b1;
    repeat (2) @(negedge clk);
    trig[3] = 1'b0;
    get_state(3, st);
    chk(st == 2'b11, "R9 second edge", st, 2'b11);
    @(negedge clk);

    // R10 same-cycle port op and line trigger
    trig[3] = 1'b1;
    access(1'b1, 2'd3, mk(3, 4'h4), rv, rd, bd, nv, ni);
    chk(nv && ni == 3'd3, "R10 eoi then trigger notify", {nv, ni}, {1'b1, 3'd3});
    chk(!nvalid, "R10 single notify", nvalid, 0);
    get_state(3, st);
    chk(st == 2'b11, "R10 eoi then trigger", st, 2'b11);
    trig[3] = 1'b0;
    access(1'b0, 2'd3, mk(4, 4'hC), rv, rd, bd, nv, ni);
    @(negedge clk);
    trig[4] = 1'b1;
    access(1'b1, 2'd3, mk(4, 4'h4), rv, rd, bd, nv, ni);
    chk(nv && ni == 3'd4 && !nvalid, "R10 00 eoi+trigger", {nv, ni}, {1'b1, 3'd4});
    get_state(4, st);
    chk(st == 2'b10, "R10 00 eoi+trigger state", st, 2'b10);
    trig[4] = 1'b0;
    trig[0] = 1'b1;
    access(1'b0, 2'd3, mk(0, 4'hD), rv, rd, bd, nv, ni);
    chk(!nv && rd == 64'd1, "R10 force off absorbs trigger", {nv, rd[1:0]}, 3'b001);
    trig[0] = 1'b0;
    @(negedge clk);

    // R11 order and hold under backpressure
    access(1'b0, 2'd3, mk(0, 4'hC), rv, rd, bd, nv, ni);
    access(1'b0, 2'd3, mk(1, 4'hC), rv, rd, bd, nv, ni);
    access(1'b0, 2'd3, mk(4, 4'hC), rv, rd, bd, nv, ni);
    nready = 1'b0;
    trig = 6'b010011;
    repeat (2) @(negedge clk);
    chk(nvalid && nidx == 3'd0, "R11 first lowest", nidx, 0);
    repeat (4) @(negedge clk);
    chk(nvalid && nidx == 3'd0, "R11 hold while stalled", nidx, 0);
    nready = 1'b1;
    @(negedge clk);
    chk(nvalid && nidx == 3'd1, "R11 second", nidx, 1);
    @(negedge clk);
    chk(nvalid && nidx == 3'd4, "R11 third", nidx, 4);
    @(negedge clk);
    chk(!nvalid, "R11 drained", nvalid, 0);
    trig = '0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule